// File: doc/BRIEF.md
# Pixel Clock Setting Search Engine

This unit turns a requested pixel clock, given in kHz, into a 12-bit control word for a display clock generator. The generator multiplies a reference clock by an integer to form a PLL frequency. It then divides that frequency by an integer divider and by two to produce the pixel clock. The control word also carries a two-bit band code that tells the PLL which frequency range it runs in.

A pulse on `start` captures the request and the reference mode. The engine then tries every multiplier and divider pair, one pair per clock, with the multiplier in the outer loop, both counting upward. A pair is discarded when its PLL frequency or its pixel clock is out of range, or when its pixel clock is above the request. Of the remaining pairs, the engine keeps the one whose pixel clock is highest. When the search ends, `done` pulses and the result appears on `word`, `valid` and `achieved_khz`. Setting `prescale_en` divides the reference by four before the PLL. This gives finer steps and a wider multiplier range, at the cost of a longer search.

Top module: `pclk_search`

## Requirements
- R1: The word is laid out as {band[11:10], multiplier[9:4], divider[3:0]}. PLL kHz = multiplier × 12000 (× 3000 in prescale mode), and pixel kHz = PLL kHz / (2 × divider).
- R2: The band code is 00 below 40000 kHz of PLL frequency, 01 from 40000, 10 from 80000 and 11 from 160000. Each lower bound is inclusive.
- R3: A pair is accepted only if PLL kHz is within 20000..228000 and pixel kHz ≤ 96000. Dividers 1..12 are tried, and in normal mode multipliers 1..19.
- R4: With prescale_en captured high, the reference is 3000 kHz and multipliers 1..63 are tried.
- R5: The result is the accepted pair with the highest pixel clock not above target_khz. achieved_khz is that pixel clock rounded down to a whole kHz.
- R6: Among pairs with equal pixel clock, the one with the lower PLL frequency (the smaller multiplier) is reported.
- R7: If no pair qualifies, valid is 0, word is 0 and achieved_khz is 0.
- R8: Call the clock edge that accepts start edge 1. done is high for exactly one cycle, after edge 2 + 12 × (multiplier count): edge 230 in normal mode and edge 758 in prescale mode. busy is high from edge 1 until that edge, and busy and done are never high together.
- R9: target_khz, prescale_en and start have no effect while busy. The result reflects the values captured at edge 1.
- R10: After reset, busy, done and valid are 0, and word and achieved_khz are 0.
- R11: word, valid and achieved_khz hold their values until the next search completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (accepted only when idle) |
| target_khz | input | 17 | Requested pixel clock in kHz |
| prescale_en | input | 1 | Use the reference divided by four |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is updated |
| valid | output | 1 | A qualifying pair was found |
| word | output | 12 | Control word {band, multiplier, divider} |
| achieved_khz | output | 17 | Pixel clock of the chosen pair, rounded down |

## Verification
In a single evaluation cycle, the engine both decides whether the current pair is better than the stored best and decides whether this is the last pair. The final pair can therefore be accepted in the same cycle as the scan ends. The bench provokes this with the request 960 kHz in prescale mode, where the winner sits at divider 11 of multiplier 7 and is followed by many losing pairs. The ceiling case 96000 kHz tests equality with the limit. Those results are judged against hand-computed words and by the exact done edge. The second overlap is a new `start` and a changed request arriving while the engine is busy. The bench checks that the word produced still matches the request captured at the first start.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } scan_st_e;
endpackage

// File: rtl/pclk_cand_eval.sv
module pclk_cand_eval #(
    parameter int TW          = 17,
    parameter int MW          = 6,
    parameter int DW          = 4,
    parameter int PW          = 18,
    parameter int REF_KHZ     = 12000,
    parameter int PRE_SHIFT   = 2,
    parameter int PLL_MIN_KHZ = 20000,
    parameter int PLL_MAX_KHZ = 228000,
    parameter int PIX_MAX_KHZ = 96000,
    parameter int BAND1_KHZ   = 40000,
    parameter int BAND2_KHZ   = 80000,
    parameter int BAND3_KHZ   = 160000
) (
    input  logic [MW-1:0] m,
    input  logic [DW-1:0] d,
    input  logic [TW-1:0] tgt,
    input  logic          pre,
    output logic          ok,
    output logic [PW-1:0] pll,
    output logic [1:0]    band
);
    localparam int XA = PW + MW;
    localparam int XB = TW + DW + 1;
    localparam int XW = (XA > XB) ? XA : XB;

    logic [XW-1:0] ref_w, pll_w, tgt_lim, pix_lim;

    always_comb begin
        ref_w   = pre ? XW'(REF_KHZ >> PRE_SHIFT) : XW'(REF_KHZ);
        pll_w   = XW'(m) * ref_w;
        tgt_lim = XW'(tgt) * XW'(d) * XW'(2);
        pix_lim = XW'(PIX_MAX_KHZ) * XW'(d) * XW'(2);
        ok      = (d != '0) && (pll_w >= XW'(PLL_MIN_KHZ)) && (pll_w <= XW'(PLL_MAX_KHZ))
                  && (pll_w <= pix_lim) && (pll_w <= tgt_lim);
        pll     = PW'(pll_w);
        if (pll_w >= XW'(BAND3_KHZ))      band = 2'b11;
        else if (pll_w >= XW'(BAND2_KHZ)) band = 2'b10;
        else if (pll_w >= XW'(BAND1_KHZ)) band = 2'b01;
        else                              band = 2'b00;
    end
endmodule

// File: rtl/pclk_best_cmp.sv
module pclk_best_cmp #(
    parameter int PW = 18,
    parameter int DW = 4
) (
    input  logic          have_best,
    input  logic [PW-1:0] pll_c,
    input  logic [DW-1:0] d_c,
    input  logic [PW-1:0] pll_b,
    input  logic [DW-1:0] d_b,
    output logic          better
);
    localparam int CW = PW + DW;
    logic [CW-1:0] lhs, rhs;

    always_comb begin
        lhs    = CW'(pll_c) * CW'(d_b);
        rhs    = CW'(pll_b) * CW'(d_c);
        better = !have_best || (lhs > rhs);
    end
endmodule

// File: rtl/pclk_rate_div.sv
module pclk_rate_div #(
    parameter int PW = 18,
    parameter int DW = 4,
    parameter int TW = 17
) (
    input  logic [PW-1:0] pll,
    input  logic [DW-1:0] d,
    output logic [TW-1:0] rate
);
    logic [PW-1:0] den, quo;

    always_comb begin
        den  = (d == '0) ? PW'(1) : (PW'(d) << 1);
        quo  = pll / den;
        rate = TW'(quo);
    end
endmodule

// File: rtl/pclk_search.sv
module pclk_search
    import pclk_pkg::*;
#(
    parameter int TW          = 17,
    parameter int MW          = 6,
    parameter int DW          = 4,
    parameter int D_MAX       = 12,
    parameter int M_MAX_NORM  = 19,
    parameter int M_MAX_PRE   = 63,
    parameter int REF_KHZ     = 12000,
    parameter int PRE_SHIFT   = 2,
    parameter int PLL_MIN_KHZ = 20000,
    parameter int PLL_MAX_KHZ = 228000,
    parameter int PIX_MAX_KHZ = 96000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [TW-1:0]        target_khz,
    input  logic                 prescale_en,
    output logic                 busy,
    output logic                 done,
    output logic                 valid,
    output logic [2+MW+DW-1:0]   word,
    output logic [TW-1:0]        achieved_khz
);
    localparam int PW = $clog2(PLL_MAX_KHZ + 1);
    localparam int WW = 2 + MW + DW;
    localparam logic [MW-1:0] M_LAST_N = MW'(M_MAX_NORM);
    localparam logic [MW-1:0] M_LAST_P = MW'(M_MAX_PRE);
    localparam logic [DW-1:0] D_LAST   = DW'(D_MAX);

    typedef struct packed {
        scan_st_e      st;
        logic [MW-1:0] m;
        logic [DW-1:0] d;
        logic [TW-1:0] tgt;
        logic          pre;
        logic          found;
        logic [MW-1:0] bm;
        logic [DW-1:0] bd;
        logic [PW-1:0] bpll;
        logic [1:0]    bband;
        logic          busy;
        logic          done;
        logic          valid;
        logic [WW-1:0] word;
        logic [TW-1:0] ach;
    } regs_t;

    regs_t r_q, r_d;

    logic          cand_ok, cand_better;
    logic [PW-1:0] cand_pll;
    logic [1:0]    cand_band;
    logic [TW-1:0] best_rate;
    logic [MW-1:0] m_last;

    pclk_cand_eval #(
        .TW(TW), .MW(MW), .DW(DW), .PW(PW), .REF_KHZ(REF_KHZ), .PRE_SHIFT(PRE_SHIFT),
        .PLL_MIN_KHZ(PLL_MIN_KHZ), .PLL_MAX_KHZ(PLL_MAX_KHZ), .PIX_MAX_KHZ(PIX_MAX_KHZ)
    ) u_eval (
        .m(r_q.m), .d(r_q.d), .tgt(r_q.tgt), .pre(r_q.pre),
        .ok(cand_ok), .pll(cand_pll), .band(cand_band)
    );

    pclk_best_cmp #(.PW(PW), .DW(DW)) u_cmp (
        .have_best(r_q.found), .pll_c(cand_pll), .d_c(r_q.d),
        .pll_b(r_q.bpll), .d_b(r_q.bd), .better(cand_better)
    );

    pclk_rate_div #(.PW(PW), .DW(DW), .TW(TW)) u_div (
        .pll(r_q.bpll), .d(r_q.bd), .rate(best_rate)
    );

    always_comb begin
        r_d    = r_q;
        r_d.done = 1'b0;
        m_last = r_q.pre ? M_LAST_P : M_LAST_N;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_SCAN;
                    r_d.m     = MW'(1);
                    r_d.d     = DW'(1);
                    r_d.tgt   = target_khz;
                    r_d.pre   = prescale_en;
                    r_d.found = 1'b0;
                    r_d.bm    = '0;
                    r_d.bd    = '0;
                    r_d.bpll  = '0;
                    r_d.bband = '0;
                    r_d.busy  = 1'b1;
                end
            end
            ST_SCAN: begin
                if (cand_ok && cand_better) begin
                    r_d.found = 1'b1;
                    r_d.bm    = r_q.m;
                    r_d.bd    = r_q.d;
                    r_d.bpll  = cand_pll;
                    r_d.bband = cand_band;
                end
                if (r_q.d == D_LAST) begin
                    r_d.d = DW'(1);
                    if (r_q.m == m_last) r_d.st = ST_FINISH;
                    else                 r_d.m  = r_q.m + MW'(1);
                end else begin
                    r_d.d = r_q.d + DW'(1);
                end
            end
            ST_FINISH: begin
                r_d.st    = ST_IDLE;
                r_d.busy  = 1'b0;
                r_d.done  = 1'b1;
                r_d.valid = r_q.found;
                r_d.word  = r_q.found ? {r_q.bband, r_q.bm, r_q.bd} : '0;
                r_d.ach   = r_q.found ? best_rate : '0;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy         = r_q.busy;
    assign done         = r_q.done;
    assign valid        = r_q.valid;
    assign word         = r_q.word;
    assign achieved_khz = r_q.ach;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !valid) |-> (word == '0 && achieved_khz == '0));
    assert_under_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && valid) |-> (achieved_khz <= r_q.tgt));
    assert_pix_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (achieved_khz <= TW'(PIX_MAX_KHZ)));
    assert_div_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && valid) |-> (word[DW-1:0] != '0 && word[DW-1:0] <= D_LAST));
    assert_word_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(rst_n)) |-> ($stable(word) && $stable(valid)));
endmodule

// File: tb/tb_pclk_search.sv
module tb_pclk_search;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [16:0] target_khz = '0;
    logic        prescale_en = 1'b0;
    logic        busy, done, valid;
    logic [11:0] word;
    logic [16:0] achieved_khz;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pclk_search dut (
        .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
        .prescale_en(prescale_en), .busy(busy), .done(done), .valid(valid),
        .word(word), .achieved_khz(achieved_khz)
    );

    typedef struct packed {
        logic        pre;
        logic [16:0] tgt;
        logic        v;
        logic [11:0] w;
        logic [16:0] a;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 17'd96000,  1'b1, 12'hD01, 17'd96000}, // R1 ceiling exact
        '{1'b0, 17'd100000, 1'b1, 12'hD01, 17'd96000}, // R3 108 MHz rejected
        '{1'b0, 17'd72000,  1'b1, 12'h8C1, 17'd72000}, // R2 band 10
        '{1'b0, 17'd71000,  1'b1, 12'h8B1, 17'd66000}, // R5 below request
        '{1'b0, 17'd54000,  1'b1, 12'h891, 17'd54000}, // R6 M9 over M18
        '{1'b0, 17'd24000,  1'b1, 12'h441, 17'd24000}, // R2 band 01
        '{1'b0, 17'd18000,  1'b1, 12'h031, 17'd18000}, // R2 band 00
        '{1'b0, 17'd84000,  1'b1, 12'hCE1, 17'd84000}, // R2 band 11
        '{1'b0, 17'd1000,   1'b1, 12'h02C, 17'd1000},  // R3 lowest PLL pair
        '{1'b0, 17'd999,    1'b0, 12'h000, 17'd0},     // R7 none fits
        '{1'b0, 17'd95999,  1'b1, 12'hCF1, 17'd90000}, // R5
        '{1'b1, 17'd96000,  1'b1, 12'hFF1, 17'd94500}, // R4 M63
        '{1'b1, 17'd73000,  1'b1, 12'hB01, 17'd72000}, // R4
        '{1'b1, 17'd45000,  1'b1, 12'h9E1, 17'd45000}, // R6 M30 over M60
        '{1'b1, 17'd960,    1'b1, 12'h07B, 17'd954},   // R5 rounded down
        '{1'b1, 17'd874,    1'b0, 12'h000, 17'd0},     // R7
        '{1'b1, 17'd875,    1'b1, 12'h07C, 17'd875},   // R4 lowest pair
        '{1'b0, 17'd131071, 1'b1, 12'hD01, 17'd96000}  // R5 max request
    };

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", what, act, act, exp, exp);
        end
    endtask

    task automatic run_search(input logic pre, input logic [16:0] tgt, output int cycles,
                              output int busy_gaps);
        @(negedge clk);
        target_khz  = tgt;
        prescale_en = pre;
        start       = 1'b1;
        @(posedge clk);
        cycles    = 1;
        busy_gaps = 0;
        @(negedge clk);
        start = 1'b0;
        while (!done && cycles < 2000) begin
            if (!busy) busy_gaps++;
            @(posedge clk);
            cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc, gaps;
        logic [11:0] held_w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !valid, "R10 flags after reset", {busy, done, valid}, 0);
        chk(word == 12'h0 && achieved_khz == 17'd0, "R10 word after reset", word, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(word == 12'h0 && !busy, "R10 idle after release", word, 0);

        for (int i = 0; i < NV; i++) begin
            run_search(VECS[i].pre, VECS[i].tgt, cyc, gaps);
            chk(valid == VECS[i].v, $sformatf("R7 valid vec %0d", i), valid, VECS[i].v);
            chk(word == VECS[i].w, $sformatf("R1 R5 word vec %0d", i), word, VECS[i].w);
            chk(achieved_khz == VECS[i].a, $sformatf("R5 achieved vec %0d", i),
                achieved_khz, VECS[i].a);
        end

        // R8 timing, normal and prescale
        run_search(1'b0, 17'd72000, cyc, gaps);
        chk(cyc == 230, "R8 normal done edge", cyc, 230);
        chk(gaps == 0 && !busy, "R8 busy during normal scan", gaps, 0);
        @(negedge clk);
        chk(!done, "R8 done one cycle", done, 0);
        run_search(1'b1, 17'd72000, cyc, gaps);
        chk(cyc == 758, "R8 prescale done edge", cyc, 758);
        chk(gaps == 0 && !busy, "R8 busy during prescale scan", gaps, 0);

        // R9 inputs and start ignored while busy
        @(negedge clk);
        target_khz = 17'd72000; prescale_en = 1'b0; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        target_khz = 17'd24000; prescale_en = 1'b1; start = 1'b1;
        repeat (5) @(negedge clk);
        start = 1'b0;
        cyc = 46;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk(word == 12'h8C1, "R9 word from captured request", word, 12'h8C1);
        chk(cyc == 230, "R9 restart ignored, done edge", cyc, 230);

        // R11 result holds after completion
        held_w = word;
        repeat (25) @(negedge clk);
        chk(word == held_w && valid && achieved_khz == 17'd72000, "R11 result held",
            word, held_w);
        chk(!done && !busy, "R11 no spurious done", {done, busy}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule